// File: doc/BRIEF.md
# Three-Slot Bundle Format Decoder

This block sits right after instruction fetch. It looks at a 64-bit fetch buffer and decides whether the buffer holds a wide bundle, using the four length bits at the bottom of the word. A wide bundle carries three independent sub-instructions, called slots. The base slot is general purpose. The memory slot mostly does loads and stores. The arithmetic slot has no memory or control-flow work.

For each slot the decoder pulls out a 6-bit opcode index. It checks that index against the range of operations that slot is allowed to hold, and produces a one-hot enable vector that the slot's execution lane can use directly. Opcode index 0 is the idle operation of every slot, so a compiler can leave any lane empty.

All outputs are registered. They appear one clock after a buffer is presented with its strobe high, and they hold until the next strobed buffer. A single flag reports a bundle in which any lane names an operation that lane cannot perform.

Top module: `lbd_top`

## Requirements
- R1: A strobed buffer whose bits [3:0] equal 4'hF is a wide bundle. `long_o` reports this one clock after the strobe. Any other value of those bits gives `long_o` = 0.
- R2: `valid_o` is `valid_i` delayed by one clock. While `valid_i` is low, every other output keeps its value, even if the buffer changes.
- R3: The opcode fields sit at fixed bit positions: slot 0 at bits [23:18], slot 1 at bits [43:38] and slot 2 at bits [63:58]. `op_o[s]` reports slot s's opcode. The other bits of each slot have no effect on any output.
- R4: `nop_o[s]` is 1 exactly when the word is a wide bundle and slot s's opcode equals 0.
- R5: For a legal opcode k in slot s of a wide bundle, `en_o[s]` is one-hot with only bit k set. For an opcode outside the slot's range, `en_o[s]` is all zero.
- R6: The legal opcode ranges are: slot 0 (base) 0..38, slot 1 (memory) 0..11, slot 2 (arithmetic) 0..13.
- R7: `illegal_o` is 1 exactly when the word is a wide bundle and at least one slot's opcode lies outside that slot's range.
- R8: When a strobed word is not a wide bundle, `op_o`, `nop_o`, `en_o` and `illegal_o` are all zero.
- R9: While `rst_n` is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Buffer strobe |
| ibuf_i | input | 64 | Fetched instruction buffer |
| valid_o | output | 1 | Decoded outputs updated this cycle |
| long_o | output | 1 | Word is a wide bundle |
| op_o | output | 3x6 | Opcode index per slot |
| nop_o | output | 3 | Idle operation per slot |
| en_o | output | 3x39 | One-hot operation enable per slot |
| illegal_o | output | 1 | Some slot holds a disallowed operation |

## Verification
Within a single decoded word, the per-lane legality check and the per-lane idle and enable decoding all settle in the same cycle. So one lane can be flagged illegal while a neighbouring lane is idle or enabled, and the word-level flag must not disturb the neighbouring lanes. The bench provokes this in two ways:
- It takes every lane's boundary values (0, last legal, first illegal, 63) and crosses them over all three lanes.
- It sweeps each lane through all 64 opcodes while the other two lanes hold random legal opcodes and every non-opcode bit is random.

Each result is judged against enables, idle flags and the word flag computed in the bench from the stated lane ranges.

// File: rtl/lbd_pkg.sv
package lbd_pkg;
  localparam int WORD_W   = 64;
  localparam int LEN_W    = 4;
  localparam int NSLOT    = 3;
  localparam int SLOT_W   = (WORD_W - LEN_W) / NSLOT;
  localparam int OPC_W    = 6;
  localparam int OPC_LSB  = SLOT_W - OPC_W;
  localparam logic [LEN_W-1:0] LONG_CODE = 4'hF;

  // Highest legal opcode index of each lane (index 0 is that lane's idle op)
  localparam int LAST_BASE = 38;
  localparam int LAST_MEM  = 11;
  localparam int LAST_ALU  = 13;
  localparam int EN_W      = LAST_BASE + 1;

  function automatic int slot_last(input int s);
    case (s)
      0:       return LAST_BASE;
      1:       return LAST_MEM;
      default: return LAST_ALU;
    endcase
  endfunction

  typedef struct packed {
    logic                             is_long;
    logic [NSLOT-1:0][OPC_W-1:0]      op;
    logic [NSLOT-1:0]                 nop;
    logic [NSLOT-1:0][EN_W-1:0]       en;
    logic                             illegal;
  } dec_t;
endpackage

// File: rtl/lbd_len_det.sv
module lbd_len_det #(
  parameter int LEN_W = 4,
  parameter logic [LEN_W-1:0] CODE = '1
) (
  input  logic [LEN_W-1:0] len_field_i,
  output logic             is_long_o
);
  always_comb begin
    is_long_o = (len_field_i == CODE);
  end
endmodule

// File: rtl/lbd_slot_dec.sv
module lbd_slot_dec #(
  parameter int OPC_W = 6,
  parameter int LAST  = 13,
  parameter int EN_W  = 39
) (
  input  logic [OPC_W-1:0] opc_i,
  output logic             is_nop_o,
  output logic             legal_o,
  output logic [EN_W-1:0]  en_o
);
  localparam logic [OPC_W-1:0] LAST_C = OPC_W'(LAST);

  always_comb begin
    is_nop_o = (opc_i == '0);
    legal_o  = (opc_i <= LAST_C);
  end

  for (genvar i = 0; i < EN_W; i++) begin : g_en
    if (i <= LAST) begin : g_live
      assign en_o[i] = (opc_i == OPC_W'(i));
    end else begin : g_dead
      assign en_o[i] = 1'b0;
    end
  end
endmodule

// File: rtl/lbd_top.sv
module lbd_top
  import lbd_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        valid_i,
  input  logic [WORD_W-1:0]           ibuf_i,
  output logic                        valid_o,
  output logic                        long_o,
  output logic [NSLOT-1:0][OPC_W-1:0] op_o,
  output logic [NSLOT-1:0]            nop_o,
  output logic [NSLOT-1:0][EN_W-1:0]  en_o,
  output logic                        illegal_o
);
  logic                        is_long;
  logic [NSLOT-1:0][OPC_W-1:0] opc;
  logic [NSLOT-1:0]            s_nop;
  logic [NSLOT-1:0]            s_legal;
  logic [NSLOT-1:0][EN_W-1:0]  s_en;
  dec_t                        dec_nxt;
  dec_t                        dec_q;
  logic                        vld_q;
  logic                        unused_bits;

  assign unused_bits = ^ibuf_i;

  lbd_len_det #(.LEN_W(LEN_W), .CODE(LONG_CODE)) u_len (
    .len_field_i (ibuf_i[LEN_W-1:0]),
    .is_long_o   (is_long)
  );

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    localparam int BASE = LEN_W + s * SLOT_W;
    assign opc[s] = ibuf_i[BASE + OPC_LSB +: OPC_W];

    lbd_slot_dec #(.OPC_W(OPC_W), .LAST(slot_last(s)), .EN_W(EN_W)) u_dec (
      .opc_i    (opc[s]),
      .is_nop_o (s_nop[s]),
      .legal_o  (s_legal[s]),
      .en_o     (s_en[s])
    );
  end

  // next-state
  always_comb begin
    dec_nxt = '0;
    if (is_long) begin
      dec_nxt.is_long = 1'b1;
      dec_nxt.op      = opc;
      dec_nxt.nop     = s_nop;
      dec_nxt.en      = s_en;
      dec_nxt.illegal = |(~s_legal);
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      dec_q <= '0;
    end else begin
      vld_q <= valid_i;
      if (valid_i) begin
        dec_q <= dec_nxt;
      end
    end
  end

  assign valid_o   = vld_q;
  assign long_o    = dec_q.is_long;
  assign op_o      = dec_q.op;
  assign nop_o     = dec_q.nop;
  assign en_o      = dec_q.en;
  assign illegal_o = dec_q.illegal;

  // assertions
  p_len_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i |=> (long_o == ($past(ibuf_i[LEN_W-1:0]) == LONG_CODE)));

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> ($stable(long_o) && $stable(illegal_o) && $stable(en_o) && !valid_o));

  p_short_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !long_o |-> (en_o == '0 && nop_o == '0 && !illegal_o && op_o == '0));

  for (genvar s = 0; s < NSLOT; s++) begin : g_chk
    p_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(en_o[s]));
    p_nop_en_r4: assert property (@(posedge clk) disable iff (!rst_n)
      nop_o[s] |-> en_o[s][0]);
    p_legal_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (long_o && !illegal_o) |-> (en_o[s] != '0));
  end
endmodule

// File: tb/test_lbd_top.sv
module test_lbd_top;
  import lbd_pkg::*;

  logic                        clk = 1'b0;
  logic                        rst_n;
  logic                        valid_i;
  logic [63:0]                 ibuf_i;
  logic                        valid_o;
  logic                        long_o;
  logic [NSLOT-1:0][OPC_W-1:0] op_o;
  logic [NSLOT-1:0]            nop_o;
  logic [NSLOT-1:0][EN_W-1:0]  en_o;
  logic                        illegal_o;

  int checks = 0;
  int errors = 0;

  lbd_top i_lbd_top (
    .clk, .rst_n, .valid_i, .ibuf_i, .valid_o, .long_o,
    .op_o, .nop_o, .en_o, .illegal_o
  );

  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  function automatic int last_of(input int s);
    case (s)
      0: return 38;
      1: return 11;
      default: return 13;
    endcase
  endfunction

  function automatic logic [5:0] opc_at(input logic [63:0] w, input int s);
    case (s)
      0: return w[23:18];
      1: return w[43:38];
      default: return w[63:58];
    endcase
  endfunction

  function automatic logic [63:0] make_word(input logic [5:0] o0, input logic [5:0] o1,
                                            input logic [5:0] o2, input logic [3:0] len);
    logic [63:0] w;
    w = {$urandom, $urandom};
    w[3:0]   = len;
    w[23:18] = o0;
    w[43:38] = o1;
    w[63:58] = o2;
    return w;
  endfunction

  task automatic expect_word(input logic [63:0] w, input string req);
    bit lg;
    bit ill;
    lg  = (w[3:0] == 4'hF);
    ill = 1'b0;
    chk(valid_o === 1'b1, "R2", {req, " valid_o"}, 64'(valid_o), 64'd1);
    chk(long_o === lg, "R1", {req, " long_o"}, 64'(long_o), 64'(lg));
    for (int s = 0; s < 3; s++) begin
      logic [5:0]  o;
      logic [38:0] een;
      o   = opc_at(w, s);
      een = '0;
      if (lg && int'(o) <= last_of(s)) een[o] = 1'b1;
      if (lg && int'(o) > last_of(s)) ill = 1'b1;
      chk(op_o[s] === (lg ? o : 6'd0), "R3", {req, " op_o"}, 64'(op_o[s]), 64'(lg ? o : 6'd0));
      chk(nop_o[s] === (lg && o == 6'd0), "R4", {req, " nop_o"}, 64'(nop_o[s]), 64'(lg && o == 6'd0));
      chk(en_o[s] === een, "R5 R6", {req, " en_o"}, 64'(en_o[s]), 64'(een));
    end
    chk(illegal_o === ill, "R7", {req, " illegal_o"}, 64'(illegal_o), 64'(ill));
  endtask

  task automatic apply(input logic [63:0] w, input string req);
    @(negedge clk);
    ibuf_i  = w;
    valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
    expect_word(w, req);
  endtask

  task automatic t_reset;
    chk(valid_o === 1'b0 && long_o === 1'b0 && illegal_o === 1'b0, "R9", "ctl at reset",
        {61'd0, valid_o, long_o, illegal_o}, 64'd0);
    chk(en_o === '0 && nop_o === '0 && op_o === '0, "R9", "slots at reset",
        64'(en_o[0]), 64'd0);
  endtask

  task automatic t_len;
    for (int n = 0; n < 16; n++) apply(make_word(6'd1, 6'd2, 6'd3, 4'(n)), "R1 len sweep");
  endtask

  task automatic t_short;
    apply(make_word(6'd63, 6'd63, 6'd63, 4'h7), "R8 short illegal ops");
    apply(make_word(6'd0, 6'd0, 6'd0, 4'hE), "R8 short zero ops");
    apply(make_word(6'd5, 6'd40, 6'd0, 4'h0), "R8 short mixed");
  endtask

  task automatic t_sweep;
    for (int s = 0; s < 3; s++) begin
      for (int v = 0; v < 64; v++) begin
        logic [5:0] o[3];
        for (int k = 0; k < 3; k++) o[k] = 6'($urandom_range(0, last_of(k)));
        o[s] = 6'(v);
        apply(make_word(o[0], o[1], o[2], 4'hF), "R3 R6 sweep");
      end
    end
  endtask

  task automatic t_cross;
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        for (int c = 0; c < 4; c++) begin
          int sel[3];
          logic [5:0] o[3];
          sel[0] = a; sel[1] = b; sel[2] = c;
          for (int k = 0; k < 3; k++)
            case (sel[k])
              0: o[k] = 6'd0;
              1: o[k] = 6'(last_of(k));
              2: o[k] = 6'(last_of(k) + 1);
              default: o[k] = 6'd63;
            endcase
          apply(make_word(o[0], o[1], o[2], 4'hF), "R7 cross");
        end
  endtask

  task automatic t_hold;
    logic [63:0] w;
    w = make_word(6'd38, 6'd0, 6'd14, 4'hF);
    apply(w, "R2 hold setup");
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      ibuf_i = make_word(6'd0, 6'd1, 6'd1, 4'h3);
      @(negedge clk);
      chk(valid_o === 1'b0, "R2", "valid_o idle", 64'(valid_o), 64'd0);
      chk(long_o === 1'b1 && illegal_o === 1'b1, "R2", "held flags",
          {62'd0, long_o, illegal_o}, 64'd3);
      chk(en_o[0] === (39'd1 << 38) && en_o[2] === '0, "R2", "held enables",
          64'(en_o[0]), 64'(39'd1 << 38));
    end
  endtask

  initial begin
    #(4 * 190000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n   = 1'b0;
    valid_i = 1'b0;
    ibuf_i  = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_len();
    t_short();
    t_sweep();
    t_cross();
    t_hold();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule